// File: doc/BRIEF.md
# I2C Quiesce-Then-Write Injector

This block is a one-shot I2C write controller for a bus it shares with another, busy controller. It cannot rely on spotting a natural gap in that controller's traffic, so it makes one. On a start request it holds the serial clock low for a long, fixed interval, which stalls the other controller. It then releases the clock and watches it until the line has stayed high for an unbroken idle window. Only after that does it send a fixed sequence of three register writes to a single target.

Both bus lines are open-drain. The block only ever drives a line low or leaves it released. It reads back the actual line levels through two-flop synchronisers. Serial timing is built from quarter-period steps of the system clock. The hold and idle intervals are cycle-count parameters, so a bench can shorten them. After the last write, or after a refused byte, the block goes quiet and waits for the next start request.

Top module: `i2c_quiesce_injector`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `done` and `err` are all 0.
- R2: A `start` pulse accepted while idle makes `scl_oe` go high and stay high for exactly `HOLD_CYCLES` consecutive clock cycles, after which it is released.
- R3: The first START condition is issued only after the synchronised SCL has been seen high on more than `IDLE_CYCLES` consecutive cycles. Any low sample during the wait restarts the count.
- R4: Each transaction consists of a START, then four bytes sent MSB first, each followed by an acknowledge clock, then a STOP. The four bytes are: the address byte 0xB0 (7-bit target 0x58 with write bit 0), a register index, a data high byte and a data low byte. Each transaction produces 37 SCL rising edges: 36 for the bytes and acknowledges, plus 1 for the STOP.
- R5: Exactly three transactions are sent, in this order: index 0x4B with data 0x8108, index 0x49 with data 0xD75C, and index 0x3F with data 0x4A07.
- R6: Within a transaction, one SCL period is 4×`QTR_CYCLES` cycles plus the input synchroniser delay. The high time is 2×`QTR_CYCLES` cycles, counted from the moment SCL is seen high. With the default parameters the clock rate is 50 kHz.
- R7: If a target holds SCL low after the block releases it, the block waits, and starts timing the high phase only once SCL is sampled high. No bit is lost.
- R8: If SDA is read high during an acknowledge clock, the block sends a STOP, sends no further bytes, and raises `err`. `err` stays high until the next accepted `start`, which clears it.
- R9: `done` pulses for exactly one cycle after the STOP of the third fully acknowledged transaction. `done` and `err` are never high together.
- R10: A `start` request that arrives while a sequence is running is ignored. Once the sequence ends, both line drivers stay released until a new `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the sequence once |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle pulse when all three writes were acknowledged |
| err | output | 1 | Set when a byte was not acknowledged; cleared by the next start |

## Verification
The bench puts a short low glitch on SCL during the idle wait. A design that only looked for a single high sample, or that did not restart its count, would begin its START far too early after the glitch. A target model holds SCL low for longer than a whole high phase after every falling edge. A controller that ignored this would pull the clock low again before the target ever saw a rising edge, and the captured bytes would come out wrong. A refused data byte checks that the block stops right away: it must send no fourth byte, no further START, and must not pulse `done` by mistake. Extra start requests during the hold and during the transfer check that the sequence is neither restarted nor repeated.

// File: rtl/i2c_inj_pkg.sv
package i2c_inj_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HOLD,
        SEQ_WAIT,
        SEQ_XFER
    } seq_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_BIT,
        LN_STOP
    } ln_e;

    localparam int N_XFER = 3;

    // Register index, data high, data low for each transaction, in send order.
    function automatic logic [23:0] xfer_payload(input logic [1:0] i);
        case (i)
            2'd0:    return 24'h4B8108;
            2'd1:    return 24'h49D75C;
            default: return 24'h3F4A07;
        endcase
    endfunction

endpackage

// File: rtl/i2c_inj_span.sv
// Counts consecutive cycles with run high; clears when run drops.
module i2c_inj_span #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (cnt_q == W'(LIMIT))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/i2c_inj_link.sv
// Bit-level engine: one START, four bytes with acknowledge clocks, one STOP.
module i2c_inj_link
    import i2c_inj_pkg::*;
#(
    parameter int QTR_CYCLES = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [31:0] frame,
    input  logic        scl_s,
    input  logic        sda_s,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        fin,
    output logic        nack
);
    localparam int CW = $clog2(2 * QTR_CYCLES + 1);

    typedef struct packed {
        ln_e          st;
        logic [1:0]   ph;
        logic [CW-1:0] cnt;
        logic [3:0]   bitn;
        logic [1:0]   byten;
        logic [31:0]  sh;
        logic         scl_oe;
        logic         sda_oe;
        logic         fin;
        logic         nack;
    } link_t;

    link_t d, q;
    logic  tq, th;

    always_comb begin
        d      = q;
        d.fin  = 1'b0;
        tq     = (q.cnt == CW'(QTR_CYCLES - 1));
        th     = (q.cnt == CW'(2 * QTR_CYCLES - 1));
        d.cnt  = q.cnt + 1'b1;
        case (q.st)
            LN_IDLE: begin
                d.cnt    = '0;
                d.scl_oe = 1'b0;
                d.sda_oe = 1'b0;
                if (go) begin
                    d.st    = LN_START;
                    d.ph    = 2'd0;
                    d.sh    = frame;
                    d.nack  = 1'b0;
                    d.byten = 2'd0;
                    d.bitn  = 4'd0;
                end
            end
            LN_START: begin
                if (tq) begin
                    d.cnt = '0;
                    if (q.ph == 2'd0) begin
                        d.sda_oe = 1'b1;
                        d.ph     = 2'd1;
                    end else begin
                        d.scl_oe = 1'b1;
                        d.ph     = 2'd0;
                        d.st     = LN_BIT;
                    end
                end
            end
            LN_BIT: begin
                case (q.ph)
                    2'd0: begin
                        d.sda_oe = (q.bitn == 4'd8) ? 1'b0 : ~q.sh[31];
                        if (tq) begin
                            d.cnt    = '0;
                            d.scl_oe = 1'b0;
                            d.ph     = 2'd1;
                        end
                    end
                    2'd1: begin
                        if (!scl_s) begin
                            d.cnt = '0;
                        end else if (th) begin
                            d.cnt    = '0;
                            d.scl_oe = 1'b1;
                            d.ph     = 2'd2;
                            if (q.bitn == 4'd8) d.nack = sda_s;
                            else                d.sh   = {q.sh[30:0], 1'b0};
                        end
                    end
                    default: begin
                        if (tq) begin
                            d.cnt = '0;
                            d.ph  = 2'd0;
                            if (q.bitn != 4'd8) begin
                                d.bitn = q.bitn + 4'd1;
                            end else begin
                                d.bitn = 4'd0;
                                if (q.nack || q.byten == 2'd3) d.st = LN_STOP;
                                else d.byten = q.byten + 2'd1;
                            end
                        end
                    end
                endcase
            end
            LN_STOP: begin
                case (q.ph)
                    2'd0: begin
                        d.sda_oe = 1'b1;
                        if (tq) begin
                            d.cnt    = '0;
                            d.scl_oe = 1'b0;
                            d.ph     = 2'd1;
                        end
                    end
                    2'd1: begin
                        if (!scl_s) begin
                            d.cnt = '0;
                        end else if (tq) begin
                            d.cnt    = '0;
                            d.sda_oe = 1'b0;
                            d.ph     = 2'd2;
                        end
                    end
                    default: begin
                        if (tq) begin
                            d.cnt = '0;
                            d.ph  = 2'd0;
                            d.st  = LN_IDLE;
                            d.fin = 1'b1;
                        end
                    end
                endcase
            end
            default: d.st = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= LN_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;
    assign fin    = q.fin;
    assign nack   = q.nack;
endmodule

// File: rtl/i2c_quiesce_injector.sv
module i2c_quiesce_injector
    import i2c_inj_pkg::*;
#(
    parameter int       CLK_HZ      = 50_000_000,
    parameter int       SCL_HZ      = 50_000,
    parameter int       HOLD_MS     = 300,
    parameter int       IDLE_MS     = 200,
    parameter int       HOLD_CYCLES = (CLK_HZ / 1000) * HOLD_MS,
    parameter int       IDLE_CYCLES = (CLK_HZ / 1000) * IDLE_MS,
    parameter int       QTR_CYCLES  = CLK_HZ / (4 * SCL_HZ),
    parameter bit [6:0] TGT_ADDR    = 7'h58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe,
    output logic done,
    output logic err
);
    typedef struct packed {
        seq_e       st;
        logic [1:0] idx;
        logic       go;
        logic       done;
        logic       err;
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
    } seq_t;

    seq_t d, q;
    logic scl_s, sda_s;
    logic hold_hit, idle_hit;
    logic lnk_scl_oe, lnk_sda_oe, lnk_fin, lnk_nack;
    logic [31:0] frame;

    assign scl_s = q.scl_sync[1];
    assign sda_s = q.sda_sync[1];
    assign frame = {TGT_ADDR, 1'b0, xfer_payload(q.idx)};

    i2c_inj_span #(.LIMIT(HOLD_CYCLES - 1)) u_hold (
        .clk (clk),
        .rst_n (rst_n),
        .run (q.st == SEQ_HOLD),
        .hit (hold_hit)
    );

    i2c_inj_span #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk (clk),
        .rst_n (rst_n),
        .run ((q.st == SEQ_WAIT) && scl_s),
        .hit (idle_hit)
    );

    i2c_inj_link #(.QTR_CYCLES(QTR_CYCLES)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (q.go),
        .frame  (frame),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .scl_oe (lnk_scl_oe),
        .sda_oe (lnk_sda_oe),
        .fin    (lnk_fin),
        .nack   (lnk_nack)
    );

    always_comb begin
        d          = q;
        d.go       = 1'b0;
        d.done     = 1'b0;
        d.scl_sync = {q.scl_sync[0], scl_i};
        d.sda_sync = {q.sda_sync[0], sda_i};
        case (q.st)
            SEQ_IDLE: begin
                if (start) begin
                    d.st  = SEQ_HOLD;
                    d.err = 1'b0;
                end
            end
            SEQ_HOLD: begin
                if (hold_hit) d.st = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (scl_s && idle_hit) begin
                    d.st  = SEQ_XFER;
                    d.go  = 1'b1;
                    d.idx = 2'd0;
                end
            end
            default: begin
                if (lnk_fin) begin
                    if (lnk_nack) begin
                        d.err = 1'b1;
                        d.st  = SEQ_IDLE;
                    end else if (q.idx == 2'(N_XFER - 1)) begin
                        d.done = 1'b1;
                        d.st   = SEQ_IDLE;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.go  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= SEQ_IDLE;
            q.scl_sync <= 2'b11;
            q.sda_sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign scl_oe = (q.st == SEQ_HOLD) | lnk_scl_oe;
    assign sda_oe = lnk_sda_oe;
    assign done   = q.done;
    assign err    = q.err;
endmodule

// File: rtl/i2c_inj_chk.sv
module i2c_inj_chk
    import i2c_inj_pkg::*;
#(
    parameter int IDLE_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input seq_e st,
    input logic scl_s,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic err,
    input logic lnk_fin,
    input logic lnk_nack
);
    logic [31:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hi_run <= '0;
        else if (!scl_s)           hi_run <= '0;
        else if (hi_run != '1)     hi_run <= hi_run + 32'd1;
    end

    p_hold_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_HOLD) |-> scl_oe);

    p_idle_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_XFER && $past(st) == SEQ_WAIT) |-> (hi_run > 32'(IDLE_CYCLES)));

    p_nack_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_fin && lnk_nack) |=> err);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_quiesce_injector i2c_inj_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (q.st),
    .scl_s    (q.scl_sync[1]),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .done     (done),
    .err      (err),
    .lnk_fin  (lnk_fin),
    .lnk_nack (lnk_nack)
);

// File: tb/sim_i2c_quiesce_injector.sv
`timescale 1ns/1ps
module sim_i2c_quiesce_injector;
    localparam int QTR  = 4;
    localparam int HOLD = 40;
    localparam int IDLE = 30;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic other_low = 1'b0, tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
    wire  scl_oe, sda_oe, done, err;
    wire  scl_line = !(scl_oe | other_low | tgt_scl_low);
    wire  sda_line = !(sda_oe | tgt_sda_low);

    always #5 clk = ~clk;

    i2c_quiesce_injector #(
        .HOLD_CYCLES(HOLD), .IDLE_CYCLES(IDLE), .QTR_CYCLES(QTR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .err(err)
    );

    int n_checks = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    int bitn = 0, nbytes = 0, starts = 0, stops = 0, nack_at = -1, stretch_n = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] cap [0:63];

    always @(negedge sda_line) if (scl_line) begin starts++; bitn = 0; end
    always @(posedge sda_line) if (scl_line) stops++;

    always @(posedge scl_line) begin
        if (bitn == 8) bitn = 0;
        else begin
            sh = {sh[6:0], sda_line};
            bitn++;
            if (bitn == 8) begin
                if (nbytes < 64) cap[nbytes] = sh;
                nbytes++;
            end
        end
    end

    always @(negedge scl_line) begin
        tgt_sda_low = (bitn == 8) && ((nbytes - 1) != nack_at);
        if (stretch_n > 0) begin
            tgt_scl_low = 1'b1;
            repeat (stretch_n) @(posedge clk);
            tgt_scl_low = 1'b0;
        end
    end

    // ---------------- bus monitor ----------------
    longint cyc = 0, first_sda = 0, hold_end = 0, last_rise = 0, min_iv = 0;
    int rises = 0, done_cnt = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (sda_oe && first_sda == 0) first_sda = cyc;
        if (!scl_oe && oe_prev && first_sda == 0) hold_end = cyc;
        if (scl_line && !scl_prev && first_sda != 0) begin
            rises++;
            if (last_rise != 0 && (min_iv == 0 || cyc - last_rise < min_iv))
                min_iv = cyc - last_rise;
            last_rise = cyc;
        end
        scl_prev = scl_line;
        oe_prev  = scl_oe;
    end

    logic [7:0] exp_b [0:11] = '{8'hB0, 8'h4B, 8'h81, 8'h08,
                                 8'hB0, 8'h49, 8'hD7, 8'h5C,
                                 8'hB0, 8'h3F, 8'h4A, 8'h07};

    task automatic clear_counts();
        nbytes = 0; starts = 0; stops = 0; rises = 0; done_cnt = 0;
        first_sda = 0; hold_end = 0; last_rise = 0; min_iv = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (done_cnt != 0 || err) break;
        end
    endtask

    task automatic check_bytes(input string req);
        chk(nbytes == 12, req, "byte count", nbytes, 12);
        for (int i = 0; i < 12; i++)
            chk(cap[i] == exp_b[i], req, $sformatf("byte %0d", i), cap[i], exp_b[i]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(scl_oe == 1'b0, "R1", "scl_oe", scl_oe, 0);
        chk(sda_oe == 1'b0, "R1", "sda_oe", sda_oe, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(err == 1'b0, "R1", "err", err, 0);
    endtask

    task automatic t_basic();
        int hold_len;
        clear_counts();
        pulse_start();
        hold_len = 0;
        for (int i = 0; i < 10 && !scl_oe; i++) @(negedge clk);
        while (scl_oe && hold_len < 1000) begin hold_len++; @(negedge clk); end
        chk(hold_len == HOLD, "R2", "hold length", hold_len, HOLD);
        wait_end();
        chk(first_sda - hold_end >= IDLE + QTR && first_sda - hold_end <= IDLE + QTR + 8,
            "R3", "release to START", first_sda - hold_end, IDLE + QTR + 5);
        check_bytes("R4/R5");
        chk(starts == 3, "R4", "START count", starts, 3);
        chk(stops == 3, "R4", "STOP count", stops, 3);
        chk(rises == 111, "R6", "SCL rising edges", rises, 111);
        chk(min_iv >= 4 * QTR && min_iv <= 4 * QTR + 3, "R6", "SCL period",
            min_iv, 4 * QTR + 2);
        repeat (100) @(negedge clk);
        chk(done_cnt == 1, "R9", "done cycles", done_cnt, 1);
        chk(err == 1'b0, "R9", "err after success", err, 0);
        chk(!scl_oe && !sda_oe, "R10", "lines released after end", scl_oe | sda_oe, 0);
    endtask

    task automatic t_glitch();
        longint rel;
        clear_counts();
        pulse_start();
        for (int i = 0; i < 10 && !scl_oe; i++) @(negedge clk);
        while (scl_oe) @(negedge clk);
        repeat (10) @(negedge clk);
        other_low = 1'b1;
        repeat (3) @(negedge clk);
        other_low = 1'b0;
        rel = cyc;
        wait_end();
        chk(first_sda - rel >= IDLE + QTR && first_sda - rel <= IDLE + QTR + 8,
            "R3", "glitch restarts idle window", first_sda - rel, IDLE + QTR + 5);
        chk(done_cnt == 1, "R3", "done after glitch", done_cnt, 1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_nack();
        clear_counts();
        nack_at = 2;
        pulse_start();
        wait_end();
        repeat (50) @(negedge clk);
        chk(err == 1'b1, "R8", "err raised", err, 1);
        chk(done_cnt == 0, "R8", "no done on NACK", done_cnt, 0);
        chk(nbytes == 3, "R8", "bytes before stop", nbytes, 3);
        chk(starts == 1, "R8", "START count", starts, 1);
        chk(stops == 1, "R8", "STOP count", stops, 1);
        chk(!scl_oe && !sda_oe, "R10", "lines released after NACK", scl_oe | sda_oe, 0);
        nack_at = -1;
    endtask

    task automatic t_busy_start();
        clear_counts();
        pulse_start();
        @(negedge clk);
        chk(err == 1'b0, "R8", "err cleared by start", err, 0);
        repeat (5) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 2000 && first_sda == 0; i++) @(negedge clk);
        repeat (100) @(negedge clk);
        pulse_start();
        wait_end();
        repeat (300) @(negedge clk);
        chk(done_cnt == 1, "R10", "single done despite extra starts", done_cnt, 1);
        chk(starts == 3, "R10", "START count", starts, 3);
        chk(nbytes == 12, "R10", "byte count", nbytes, 12);
    endtask

    task automatic t_stretch();
        clear_counts();
        pulse_start();
        for (int i = 0; i < 2000 && first_sda == 0; i++) @(negedge clk);
        stretch_n = 15;
        wait_end();
        stretch_n = 0;
        repeat (50) @(negedge clk);
        check_bytes("R7");
        chk(done_cnt == 1, "R7", "done with stretching", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_glitch();
        t_nack();
        t_busy_start();
        t_stretch();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule